// File: doc/BRIEF.md
# Serial Port Status and Interrupt Request Logic

This block keeps the status word of an asynchronous serial port and produces its single interrupt request. The receive datapath sends it one-cycle strobes: a character was loaded into the receive data register, with the sampled stop bit and the parity check result alongside, and a break was detected. The transmit datapath sends two levels that say whether the holding register and the shift register are empty. The register bus reads the 16-bit status word and can write it to clear flags. A strobe from the bus marks each read of the receive data register.

Error flags stay set until software clears them, by writing 0 to the flag's bit. The receive-ready flag is cleared as a side effect of a data-register read. The transmit empty indications follow the datapath. The interrupt output is the OR of three requests. The transmit request is held for as long as the holding register is empty and its enable is set. The receive request is held while data is ready and its enable is set. The break request comes from the break flag alone.

Top module: `sport_status_irq`

## Requirements
- R1: After reset the status word is 0000h. Bits 15 to 7 always read 0.
- R2: Bit 6 (transmitter empty) is 1 exactly when both the holding-empty input and the shift-empty input were 1 at the previous clock edge. Writes have no effect on it.
- R3: Bit 5 (holding empty) copies the holding-empty input with a delay of one clock. Writes have no effect on it.
- R4: Bit 4 (receive ready) sets on the edge that samples the character strobe. It clears on the edge that samples a data-register read strobe, or a status write with bit 4 equal to 0. A write with bit 4 equal to 1 leaves it unchanged.
- R5: Bit 3 (break) sets on the edge that samples the break strobe. While it is set, the interrupt output is 1 whatever the enables are.
- R6: Bit 2 (framing error) sets when the character strobe is sampled while the stop-bit sample is 0.
- R7: Bit 1 (parity error) sets when the character strobe is sampled with the parity-ok input at 0, but only when the 2-bit mode input is 1 or 3. In modes 0 and 2 a parity failure is ignored.
- R8: Bit 0 (overrun) sets when the character strobe is sampled while receive ready is 1 and is not being cleared in that same cycle.
- R9: Bits 3 to 0 are sticky. A status write clears each of these bits that is written as 0 and leaves each bit written as 1 unchanged. If a set event and a clear meet in the same cycle, the bit ends up set.
- R10: With the transmit enable at 1, the interrupt output is 1 in every cycle in which bit 5 is 1. With the transmit enable at 0, bit 5 does not drive the interrupt.
- R11: The interrupt output is 1 exactly when (transmit enable AND bit 5), OR (receive enable AND bit 4), OR bit 3.
- R12: If a character strobe and a data-register read happen in the same cycle, receive ready stays 1 and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_char_stb | input | 1 | A received byte was loaded into the receive data register |
| rx_stop_smp | input | 1 | Stop-bit sample, valid with rx_char_stb (1 = high) |
| rx_par_ok | input | 1 | Parity check result, valid with rx_char_stb (1 = match) |
| rx_brk_stb | input | 1 | A break was detected |
| port_mode | input | 2 | Operating mode; parity is checked in modes 1 and 3 |
| tx_hold_empty | input | 1 | Transmit holding register is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 16 | Status write data |
| rxdata_rd | input | 1 | Receive data register read strobe |
| irq_tx_en | input | 1 | Transmit interrupt enable |
| irq_rx_en | input | 1 | Receive interrupt enable |
| stat_word | output | 16 | Status word |
| serial_irq | output | 1 | Serial interrupt request |

## Verification
Every flag in the status word is a register. A strobe or level sampled at one rising edge therefore shows up in the status word from that edge on. The interrupt output is a combination of those registers, so it changes in the same cycle as the flags that drive it. The bench drives its inputs on the falling edge and updates its reference model on the rising edge, from the same input values. It compares every status bit and the interrupt at the next falling edge, one clock after the stimulus. Directed checks for same-cycle collisions and ignored writes sample at that same point, before the next stimulus is applied.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int STAT_W = 16;
  localparam int ERR_N  = 4;
  localparam int B_OVR  = 0;
  localparam int B_PAR  = 1;
  localparam int B_FRM  = 2;
  localparam int B_BRK  = 3;
  localparam int B_RDY  = 4;
  localparam int B_HOLD = 5;
  localparam int B_IDLE = 6;
  localparam int USED_W = 7;

  // sticky bit: a set event wins over a clear in the same cycle
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // parity is checked only in the odd-numbered modes
  function automatic logic parity_checked(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic idle, input logic hold, input logic rdy, input logic [ERR_N-1:0] err);
    logic [STAT_W-1:0] w;
    w = '0;
    w[B_IDLE] = idle;
    w[B_HOLD] = hold;
    w[B_RDY]  = rdy;
    w[ERR_N-1:0] = err;
    return w;
  endfunction
endpackage

// File: rtl/sps_tx_flags.sv
module sps_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_empty,
  input  logic shift_empty,
  output logic hold_flag,
  output logic idle_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_flag <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      hold_flag <= hold_empty;
      idle_flag <= hold_empty & shift_empty;
    end
  end
endmodule

// File: rtl/sps_rx_flags.sv
module sps_rx_flags
  import sps_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int STAT_W_P = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_stb,
  input  logic              stop_smp,
  input  logic              par_ok,
  input  logic              brk_stb,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr,
  input  logic [STAT_W_P-1:0] wdata,
  input  logic              rd,
  output logic              rdy_flag,
  output logic [ERR_N-1:0]  err_flags,
  output logic              rdy_clr,
  output logic [ERR_N-1:0]  err_set,
  output logic [ERR_N-1:0]  err_clr
);
  logic par_mode;

  assign par_mode = parity_checked(mode[1:0]);
  assign rdy_clr  = rd | (wr & ~wdata[B_RDY]);
  assign err_clr  = {ERR_N{wr}} & ~wdata[ERR_N-1:0];

  always_comb begin
    err_set        = '0;
    err_set[B_OVR] = char_stb & rdy_flag & ~rdy_clr;
    err_set[B_PAR] = char_stb & par_mode & ~par_ok;
    err_set[B_FRM] = char_stb & ~stop_smp;
    err_set[B_BRK] = brk_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_flag <= 1'b0;
    else        rdy_flag <= sticky_next(rdy_flag, char_stb, rdy_clr);
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_flags[i] <= 1'b0;
      else        err_flags[i] <= sticky_next(err_flags[i], err_set[i], err_clr[i]);
    end
  end
endmodule

// File: rtl/sps_irq_ctrl.sv
module sps_irq_ctrl (
  input  logic hold_flag,
  input  logic rdy_flag,
  input  logic brk_flag,
  input  logic tx_en,
  input  logic rx_en,
  output logic tx_req,
  output logic rx_req,
  output logic brk_req,
  output logic irq
);
  assign tx_req  = tx_en & hold_flag;
  assign rx_req  = rx_en & rdy_flag;
  assign brk_req = brk_flag;
  assign irq     = tx_req | rx_req | brk_req;
endmodule

// File: rtl/sport_status_irq.sv
module sport_status_irq
  import sps_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_char_stb,
  input  logic              rx_stop_smp,
  input  logic              rx_par_ok,
  input  logic              rx_brk_stb,
  input  logic [MODE_W-1:0] port_mode,
  input  logic              tx_hold_empty,
  input  logic              tx_shift_empty,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] stat_wdata,
  input  logic              rxdata_rd,
  input  logic              irq_tx_en,
  input  logic              irq_rx_en,
  output logic [WORD_W-1:0] stat_word,
  output logic              serial_irq
);
  logic             hold_flag, idle_flag, rdy_flag;
  logic [ERR_N-1:0] err_flags, err_set, err_clr;
  logic             rdy_clr;
  logic             tx_req, rx_req, brk_req;

  sps_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n),
    .hold_empty(tx_hold_empty), .shift_empty(tx_shift_empty),
    .hold_flag(hold_flag), .idle_flag(idle_flag)
  );

  sps_rx_flags #(.MODE_W(MODE_W), .STAT_W_P(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .char_stb(rx_char_stb), .stop_smp(rx_stop_smp), .par_ok(rx_par_ok),
    .brk_stb(rx_brk_stb), .mode(port_mode),
    .wr(stat_wr), .wdata(stat_wdata), .rd(rxdata_rd),
    .rdy_flag(rdy_flag), .err_flags(err_flags),
    .rdy_clr(rdy_clr), .err_set(err_set), .err_clr(err_clr)
  );

  sps_irq_ctrl u_irq (
    .hold_flag(hold_flag), .rdy_flag(rdy_flag), .brk_flag(err_flags[B_BRK]),
    .tx_en(irq_tx_en), .rx_en(irq_rx_en),
    .tx_req(tx_req), .rx_req(rx_req), .brk_req(brk_req), .irq(serial_irq)
  );

  logic [STAT_W-1:0] packed_w;
  assign packed_w  = pack_status(idle_flag, hold_flag, rdy_flag, err_flags);
  assign stat_word = packed_w[WORD_W-1:0];
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_char_stb,
  input logic        rxdata_rd,
  input logic        irq_tx_en,
  input logic        serial_irq,
  input logic [15:0] stat_word,
  input logic        rdy_clr,
  input logic [3:0]  err_set,
  input logic [3:0]  err_clr
);
  a_r4_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char_stb |=> stat_word[4]);
  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_stb && stat_word[4] && !rdy_clr) |=> stat_word[0]);
  a_r5_break_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_set[3] |=> serial_irq);
  a_r10_tx_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx_en && stat_word[5]) |-> serial_irq);
  a_r9_sticky_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[0] && !err_clr[0]) |=> stat_word[0]);
  a_r2_idle_implies_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[6] |-> stat_word[5]);
  a_r12_read_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_stb && rxdata_rd && !stat_word[0]) |=> (stat_word[4] && !stat_word[0]));
endmodule

bind sport_status_irq sps_checker u_chk (.*);

// File: tb/tb_sport_status_irq.sv
`timescale 1ns/1ps
module tb_sport_status_irq;
  logic clk = 0, rst_n = 0;
  logic rx_char_stb = 0, rx_stop_smp = 1, rx_par_ok = 1, rx_brk_stb = 0;
  logic [1:0] port_mode = 0;
  logic tx_hold_empty = 0, tx_shift_empty = 0;
  logic stat_wr = 0, rxdata_rd = 0, irq_tx_en = 0, irq_rx_en = 0;
  logic [15:0] stat_wdata = 16'hFFFF;
  logic [15:0] stat_word;
  logic serial_irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sport_status_irq dut (.*);

  // reference model
  bit m_idle, m_hold, m_rdy, m_brk, m_frm, m_par, m_ovr;
  always @(posedge clk) begin
    bit take;
    if (!rst_n) begin
      {m_idle, m_hold, m_rdy, m_brk, m_frm, m_par, m_ovr} = '0;
    end else begin
      take = rxdata_rd || (stat_wr && stat_wdata[4] == 0);
      if (rx_char_stb && m_rdy && !take) m_ovr = 1;
      else if (stat_wr && !stat_wdata[0]) m_ovr = 0;
      if (rx_char_stb && !rx_par_ok && (port_mode == 1 || port_mode == 3)) m_par = 1;
      else if (stat_wr && !stat_wdata[1]) m_par = 0;
      if (rx_char_stb && !rx_stop_smp) m_frm = 1;
      else if (stat_wr && !stat_wdata[2]) m_frm = 0;
      if (rx_brk_stb) m_brk = 1;
      else if (stat_wr && !stat_wdata[3]) m_brk = 0;
      if (rx_char_stb) m_rdy = 1;
      else if (take) m_rdy = 0;
      m_hold = tx_hold_empty;
      m_idle = tx_hold_empty && tx_shift_empty;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_irq;
    e_irq = (irq_tx_en && m_hold) || (irq_rx_en && m_rdy) || m_brk;
    chk("R1 reserved", stat_word[15:7], 0);
    chk("R2 idle", stat_word[6], m_idle);
    chk("R3 hold", stat_word[5], m_hold);
    chk("R4 ready", stat_word[4], m_rdy);
    chk("R5 break", stat_word[3], m_brk);
    chk("R6 framing", stat_word[2], m_frm);
    chk("R7 parity", stat_word[1], m_par);
    chk("R8 overrun", stat_word[0], m_ovr);
    chk("R11 irq", serial_irq, e_irq);
  end

  task automatic idle_strobes();
    rx_char_stb = 0; rx_brk_stb = 0; stat_wr = 0; rxdata_rd = 0;
    stat_wdata = 16'hFFFF; rx_stop_smp = 1; rx_par_ok = 1;
  endtask

  task automatic step(); @(negedge clk); idle_strobes(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", stat_word, 16'h0000);
    rst_n = 1;
    // R12: character and read together, ready already set
    rx_char_stb = 1; step();
    rx_char_stb = 1; rxdata_rd = 1; step();
    chk("R12 ready kept", stat_word[4], 1);
    chk("R12 no overrun", stat_word[0], 0);
    // R8 overrun
    rx_char_stb = 1; step();
    chk("R8 overrun set", stat_word[0], 1);
    // R9 writing 1 keeps flags
    stat_wr = 1; stat_wdata = 16'hFFFF; step();
    chk("R9 write one keeps", stat_word[0], 1);
    chk("R4 write one keeps ready", stat_word[4], 1);
    // R9 set wins over clear
    rx_char_stb = 1; rx_stop_smp = 0; stat_wr = 1; stat_wdata = 16'hFFFB; step();
    chk("R9 set wins", stat_word[2], 1);
    stat_wr = 1; stat_wdata = 16'h0000; step();
    chk("R9 clear all", stat_word[3:0], 0);
    chk("R4 write zero clears", stat_word[4], 0);
    // R7 parity modes
    port_mode = 2; rx_char_stb = 1; rx_par_ok = 0; step();
    chk("R7 mode2 ignored", stat_word[1], 0);
    port_mode = 3; rx_char_stb = 1; rx_par_ok = 0; rxdata_rd = 1; step();
    chk("R7 mode3 flagged", stat_word[1], 1);
    // R5 break raises irq without enables
    rx_brk_stb = 1; step();
    chk("R5 break irq", serial_irq, 1);
    stat_wr = 1; stat_wdata = 16'h0000; step();
    // R10 tx irq level
    tx_hold_empty = 1; tx_shift_empty = 1; step();
    chk("R10 tx disabled", serial_irq, 0);
    irq_tx_en = 1; step();
    chk("R10 tx enabled", serial_irq, 1);
    // R13-style: writes to bits 6,5 ignored (R2, R3)
    stat_wr = 1; stat_wdata = 16'h0000; step();
    chk("R2 write ignored", stat_word[6], 1);
    chk("R3 write ignored", stat_word[5], 1);
    tx_shift_empty = 0; step();
    chk("R2 shift busy", stat_word[6], 0);
    irq_tx_en = 0; irq_rx_en = 1; rx_char_stb = 1; step();
    chk("R11 rx irq", serial_irq, 1);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rx_char_stb   = ($urandom % 4) == 0;
      rx_stop_smp   = ($urandom % 4) != 0;
      rx_par_ok     = ($urandom % 3) != 0;
      rx_brk_stb    = ($urandom % 16) == 0;
      port_mode     = 2'($urandom);
      tx_hold_empty = $urandom % 2;
      tx_shift_empty= $urandom % 2;
      stat_wr       = ($urandom % 5) == 0;
      stat_wdata    = 16'($urandom);
      rxdata_rd     = ($urandom % 4) == 0;
      irq_tx_en     = $urandom % 2;
      irq_rx_en     = $urandom % 2;
    end
    step();
    @(negedge clk);
    finish_run();
  end
endmodule